// File: doc/BRIEF.md
# Trace-Based Spike-Timing Weight Learner

This block adjusts the synaptic weights of a small neuron array after the array has emitted an output spike vector. It records the presynaptic input vector at every time step in a sixteen-deep history. When an output spike vector is presented, the history is split in two. The older eight entries count as inputs that fired before the output event, and the newer eight count as inputs that fired after it. Each half is ORed into a single vector.

For every input whose bit is set in either vector, the block updates one weight row in a single cycle. The row holds one weight per postsynaptic neuron. Each neuron whose output bit is set has its weight raised by a programmable potentiation step if the input fired before the event, or lowered by a programmable depression step if it fired only after. Results saturate at the ends of the 8-bit range.

The weight store lives inside the block. It has a write port for loading weights and a combinational read port. A busy flag covers the whole update.

Top module: `stdp_updater`

## Requirements
- R1: After reset, busy is low, every weight reads 0 and the history is empty.
- R2: A learning request is skipped unless at least 16 time steps (step pulses) have been recorded since reset. A skipped request leaves busy low and the weights unchanged.
- R3: A learning request whose postsynaptic vector is all zero is skipped. It leaves busy low and the weights unchanged.
- R4: At a request, the inputs from the 8 most recent steps form the after vector and the inputs from the 8 steps before those form the before vector. Each is the OR of its 8 entries.
- R5: For an input in the before vector, the weight to every neuron whose postsynaptic bit is set rises by ltp_step and saturates at 255.
- R6: For an input only in the after vector, the weight to every neuron whose postsynaptic bit is set falls by ltd_step and saturates at 0.
- R7: An input present in both vectors is potentiated only.
- R8: Weights of neurons whose postsynaptic bit is clear, and weights of inputs in neither vector, do not change.
- R9: busy rises on the cycle after an accepted request and stays high for exactly as many cycles as there are set bits in the OR of both vectors. Requests made while busy is high are ignored.
- R10: A weight write with wr_en while busy is low stores wr_data, and the new value can be read from the following cycle. A write while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Time-step strobe; shifts pre_spikes into the history |
| pre_spikes | input | N_PRE | Presynaptic spike vector of this time step |
| post_valid | input | 1 | Learning request; output spike vector has been sent |
| post_spikes | input | N_POST | Postsynaptic spike vector for the request |
| ltp_step | input | W_BITS | Potentiation increment |
| ltd_step | input | W_BITS | Depression decrement |
| wr_en | input | 1 | Weight write strobe |
| wr_pre | input | PW | Input index of the write |
| wr_post | input | NW | Neuron index of the write |
| wr_data | input | W_BITS | Weight value to store |
| rd_pre | input | PW | Input index of the read |
| rd_post | input | NW | Neuron index of the read |
| rd_data | output | W_BITS | Weight at the read address |
| busy | output | 1 | High while weight rows are being updated |

## Verification
The bench builds the block with its defaults: 8 inputs, 4 neurons, 8-bit weights and a 16-deep history. With only 32 weights, every weight can be read back after every update. With 8 inputs, the busy window of at most 8 cycles can be measured exactly. Random step counts and sparse spike vectors exercise the before/after split at every history depth. Directed cases drive weights to 250 and 3 so that both saturation limits are reached, and place one input in both halves of the history to check that potentiation wins.

// File: rtl/stdp_updater.sv
module stdp_updater #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 4,
  parameter int W_BITS = 8,
  parameter int HIST   = 16,
  localparam int HALF  = HIST / 2,
  localparam int PW    = (N_PRE > 1) ? $clog2(N_PRE) : 1,
  localparam int NW    = (N_POST > 1) ? $clog2(N_POST) : 1,
  localparam int FW    = $clog2(HIST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [N_PRE-1:0]  pre_spikes,
  input  logic              post_valid,
  input  logic [N_POST-1:0] post_spikes,
  input  logic [W_BITS-1:0] ltp_step,
  input  logic [W_BITS-1:0] ltd_step,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_pre,
  input  logic [NW-1:0]     wr_post,
  input  logic [W_BITS-1:0] wr_data,
  input  logic [PW-1:0]     rd_pre,
  input  logic [NW-1:0]     rd_post,
  output logic [W_BITS-1:0] rd_data,
  output logic              busy
);
  localparam logic [W_BITS-1:0] WMAX = '1;

  logic [N_PRE-1:0]  hist [HIST];
  logic [FW-1:0]     fill;
  logic [N_PRE-1:0]  bef_v, aft_v, mask, bef_q, pick;
  logic [N_POST-1:0] post_q;
  logic [W_BITS-1:0] wmem [N_PRE][N_POST];
  logic [PW-1:0]     sel;
  logic              start;

  function automatic logic [W_BITS-1:0] sat_inc(input logic [W_BITS-1:0] a, input logic [W_BITS-1:0] b);
    logic [W_BITS:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W_BITS] ? WMAX : s[W_BITS-1:0];
  endfunction

  function automatic logic [W_BITS-1:0] sat_dec(input logic [W_BITS-1:0] a, input logic [W_BITS-1:0] b);
    return (a < b) ? '0 : a - b;
  endfunction

  always_comb begin
    bef_v = '0;
    aft_v = '0;
    for (int k = 0; k < HIST; k++)
      if (k < HALF) aft_v |= hist[k];
      else          bef_v |= hist[k];
  end

  assign busy    = |mask;
  assign start   = post_valid && !busy && (fill == FW'(HIST)) && |post_spikes;
  assign pick    = mask & (~mask + N_PRE'(1));
  assign rd_data = wmem[rd_pre][rd_post];

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_PRE; i++)
      if (pick[i]) sel = PW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int k = 0; k < HIST; k++) hist[k] <= '0;
    end else if (step) begin
      hist[0] <= pre_spikes;
      for (int k = 1; k < HIST; k++) hist[k] <= hist[k-1];
      if (fill != FW'(HIST)) fill <= fill + FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask   <= '0;
      bef_q  <= '0;
      post_q <= '0;
    end else if (start) begin
      mask   <= bef_v | aft_v;
      bef_q  <= bef_v;
      post_q <= post_spikes;
    end else if (busy) begin
      mask   <= mask & ~pick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_PRE; i++)
        for (int j = 0; j < N_POST; j++) wmem[i][j] <= '0;
    end else if (busy) begin
      for (int j = 0; j < N_POST; j++)
        if (post_q[j])
          wmem[sel][j] <= bef_q[sel] ? sat_inc(wmem[sel][j], ltp_step)
                                     : sat_dec(wmem[sel][j], ltd_step);
    end else if (wr_en) begin
      wmem[wr_pre][wr_post] <= wr_data;
    end
  end
endmodule

// File: rtl/stdp_updater_chk.sv
module stdp_updater_chk #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 4,
  parameter int W_BITS = 8,
  parameter int HIST   = 16,
  parameter int PW     = 3,
  parameter int NW     = 2,
  parameter int FW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              post_valid,
  input logic [N_POST-1:0] post_spikes,
  input logic [FW-1:0]     fill,
  input logic [N_PRE-1:0]  mask,
  input logic              wr_en,
  input logic [PW-1:0]     rd_pre,
  input logic [NW-1:0]     rd_post,
  input logic [W_BITS-1:0] rd_data
);
  assert_learn_needs_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fill) == FW'(HIST));

  assert_empty_post_skips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && post_valid && post_spikes == '0) |=> !busy);

  assert_one_row_per_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $countones(mask) == $countones($past(mask)) - 1);

  assert_last_row_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $countones($past(mask)) == 1);

  assert_idle_weights_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> (!($stable(rd_pre) && $stable(rd_post)) || $stable(rd_data)));
endmodule

bind stdp_updater stdp_updater_chk #(
  .N_PRE(N_PRE), .N_POST(N_POST), .W_BITS(W_BITS), .HIST(HIST),
  .PW(PW), .NW(NW), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .post_valid(post_valid),
  .post_spikes(post_spikes), .fill(fill), .mask(mask), .wr_en(wr_en),
  .rd_pre(rd_pre), .rd_post(rd_post), .rd_data(rd_data)
);

// File: tb/stdp_updater_test.sv
module stdp_updater_test;
  localparam int NP = 8, NQ = 4, WB = 8, H = 16;

  logic clk = 0, rst_n = 0, step = 0, post_valid = 0, wr_en = 0;
  logic [NP-1:0] pre_spikes = '0;
  logic [NQ-1:0] post_spikes = '0;
  logic [WB-1:0] ltp_step = 8'd4, ltd_step = 8'd2, wr_data = '0, rd_data;
  logic [2:0] wr_pre = '0, rd_pre = '0;
  logic [1:0] wr_post = '0, rd_post = '0;
  logic busy;

  int errors = 0, checks = 0;
  logic [NP-1:0] mh [H];
  int mfill = 0;
  logic [WB-1:0] mw [NP][NQ];

  always #5 clk = ~clk;

  stdp_updater uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    for (int i = 0; i < NP; i++)
      for (int j = 0; j < NQ; j++) begin
        rd_pre = 3'(i); rd_post = 2'(j); #1;
        if (rd_data != mw[i][j]) begin
          bad++;
          $display("FAIL %s weight[%0d][%0d] actual=%0d expected=%0d", tag, i, j, rd_data, mw[i][j]);
        end
      end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic do_step(input logic [NP-1:0] v);
    @(negedge clk); step = 1; pre_spikes = v;
    @(negedge clk); step = 0;
    for (int k = H - 1; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = v;
    if (mfill < H) mfill++;
  endtask

  task automatic do_write(input int i, input int j, input logic [WB-1:0] d);
    @(negedge clk); wr_en = 1; wr_pre = 3'(i); wr_post = 2'(j); wr_data = d;
    @(negedge clk); wr_en = 0;
    mw[i][j] = d;
  endtask

  function automatic logic [WB-1:0] inc(input logic [WB-1:0] a, input logic [WB-1:0] b);
    return (int'(a) + int'(b) > 255) ? 8'd255 : a + b;
  endfunction
  function automatic logic [WB-1:0] dec(input logic [WB-1:0] a, input logic [WB-1:0] b);
    return (a < b) ? 8'd0 : a - b;
  endfunction

  task automatic learn(input string tag, input logic [NQ-1:0] post, input int inject);
    logic [NP-1:0] bef = '0, aft = '0;
    int exp_cyc = 0, cyc = 0;
    for (int k = 0; k < H; k++) if (k < H/2) aft |= mh[k]; else bef |= mh[k];
    if (mfill == H && post != '0) begin
      exp_cyc = $countones(bef | aft);
      for (int i = 0; i < NP; i++)
        if ((bef | aft) & (NP'(1) << i))
          for (int j = 0; j < NQ; j++)
            if (post[j]) mw[i][j] = bef[i] ? inc(mw[i][j], ltp_step) : dec(mw[i][j], ltd_step);
    end
    @(negedge clk); post_valid = 1; post_spikes = post;
    @(negedge clk); post_valid = 0;
    while (busy && cyc < 100) begin
      if (cyc == 0 && inject == 1) begin wr_en = 1; wr_pre = 0; wr_post = 0; wr_data = 8'hAA; end
      if (cyc == 0 && inject == 2) begin post_valid = 1; post_spikes = '1; end
      @(negedge clk); cyc++;
      wr_en = 0; post_valid = 0;
    end
    check({tag, " R9 busy cycles"}, cyc, exp_cyc);
    compare_all(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d3c));
    for (int k = 0; k < H; k++) mh[k] = '0;
    for (int i = 0; i < NP; i++) for (int j = 0; j < NQ; j++) mw[i][j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    compare_all("R1 weights after reset");

    for (int i = 0; i < NP; i++) for (int j = 0; j < NQ; j++) do_write(i, j, 8'd100);
    compare_all("R10 idle writes");
    for (int s = 0; s < 15; s++) do_step(8'hFF);
    learn("R2 partial history", 4'hF, 0);
    do_step(8'h00);
    learn("R3 empty post vector", 4'h0, 0);

    ltp_step = 8'd5; ltd_step = 8'd3;
    for (int s = 0; s < 8; s++) do_step(8'h01);
    for (int s = 0; s < 8; s++) do_step(8'h02);
    learn("R4 R8 before/after split", 4'b0101, 0);

    do_write(3, 1, 8'd250); do_write(4, 2, 8'd3);
    ltp_step = 8'd10; ltd_step = 8'd9;
    for (int s = 0; s < 8; s++) do_step(s == 2 ? 8'h0C : 8'h00);
    for (int s = 0; s < 8; s++) do_step(s == 5 ? 8'h14 : 8'h00);
    learn("R5 R6 R7 saturation and overlap", 4'b0110, 0);
    check("R5 ceiling", int'(mw[3][1]), 255);
    check("R6 floor", int'(mw[4][2]), 0);

    learn("R10 write while busy", 4'b0001, 1);
    learn("R9 request while busy", 4'b1000, 2);

    for (int it = 0; it < 40; it++) begin
      ltp_step = 8'($urandom_range(0, 40));
      ltd_step = 8'($urandom_range(0, 40));
      for (int s = 0, n = $urandom_range(1, 6); s < n; s++)
        do_step(8'($urandom) & 8'($urandom) & 8'($urandom));
      if ($urandom_range(0, 3) == 0)
        do_write($urandom_range(0, NP-1), $urandom_range(0, NQ-1), 8'($urandom));
      learn("R4 R5 R6 R8 random", 4'($urandom), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule